// File: doc/BRIEF.md
# CPU-Cycle One-Shot Interrupt Timer

This block is a one-shot interrupt timer that counts CPU cycles. Software programs it through two byte-wide registers. A write to the low register parks a byte in a staging register and leaves the live count alone. A write to the high register does three things at once:

- it joins its low bits with the staged byte to form a 15-bit count;
- it takes its top bit as the run enable;
- it acknowledges any interrupt that is still pending.

While the timer runs and the count is nonzero, the count drops by one on every clock edge where the cycle enable is high. When the count reaches zero, the timer stops itself and holds its state. On the following edge it pulls the active-low interrupt line low. The line stays low until the next high-register write.

The write strobe, the register select and the data come from an address decoder outside this block. The cycle enable marks the clock edges that count as CPU cycles.

Top module: `cyc_irq_timer`

## Requirements
- R1: A write with `wr_sel`=0 (low register) stores `wr_data` in the staging register only. The running count and its interrupt timing are not changed.
- R2: A write with `wr_sel`=1 (high register) loads the count with {`wr_data`[6:0], staged byte}, a 15-bit value from 0 to 32767.
- R3: On a high-register write, `wr_data`[7] becomes the run enable. With the enable clear the count never changes and no interrupt fires.
- R4: A high-register write sets `irq_n` high on the next edge. It takes priority over an interrupt that would assert on that same edge. It also restarts a count that is already running.
- R5: While the timer is enabled and the count is nonzero, the count drops by exactly one on each edge with `cyc_en`=1. Edges with `cyc_en`=0 leave it unchanged.
- R6: When the count reaches zero, the enable clears and the count holds at zero. `irq_n` then stays low until the next high-register write.
- R7: A load of zero with the enable set never decrements and never raises an interrupt.
- R8: While `rst` is high, the count, the staging byte and the enable clear to zero and `irq_n` is high.
- R9: `irq_n` is registered. For a load of N>0 with `cyc_en` held high, `irq_n` is still high after the N-th edge following the load edge and is low after edge N+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 1 | Register select: 0 = low byte, 1 = high byte with enable |
| wr_data | input | 8 | Write data |
| cyc_en | input | 1 | High on edges that count as CPU cycles |
| irq_n | output | 1 | Active-low interrupt request, registered |

## Verification
The bench builds the timer with its default widths: an 8-bit data bus and a 15-bit count. These defaults leave 7 count bits in the high register and the enable in bit 7. With these values the full count of 32767 fits in one run, so the bench checks the largest load. It also exercises the zero load, a reload in the middle of a count, an acknowledge that lands on the same edge as the interrupt would assert, and an irregular `cyc_en` pattern. A cycle-by-cycle reference model, driven by the same stimulus, predicts `irq_n` on every clock.

// File: rtl/cit_pkg.sv
package cit_pkg;
  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/cit_stage.sv
// Staging register for the low byte of the count.
module cit_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] hold_o
);
  always_ff @(posedge clk) begin
    if (rst) hold_o <= '0;
    else if (load_i) hold_o <= data_i;
  end
endmodule

// File: rtl/cit_count.sv
// Down counter with run enable and a terminal pulse.
module cit_count #(
  parameter int CNT_W  = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] hold_i,
  input  logic              cyc_en_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              en_o,
  output logic              hit_o
);
  localparam int HI_W = CNT_W - DATA_W;
  localparam int EN_BIT = DATA_W - 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;
  assign step = cyc_en_i && en_o && (cnt_o != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      en_o  <= 1'b0;
      hit_o <= 1'b0;
    end else begin
      hit_o <= 1'b0;
      if (commit_i) begin
        cnt_o <= {data_i[HI_W-1:0], hold_i};
        en_o  <= data_i[EN_BIT];
      end else if (step) begin
        cnt_o <= cnt_o - ONE;
        if (cnt_o == ONE) begin
          en_o  <= 1'b0;
          hit_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cit_irq_out.sv
// Registered active-low interrupt line; acknowledge wins over a fire.
module cit_irq_out (
  input  logic clk,
  input  logic rst,
  input  logic ack_i,
  input  logic fire_i,
  output logic irq_n_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_n_o <= 1'b1;
    else if (ack_i) irq_n_o <= 1'b1;
    else if (fire_i) irq_n_o <= 1'b0;
  end
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer #(
  parameter int CNT_W  = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cyc_en,
  output logic              irq_n
);
  import cit_pkg::*;

  reg_sel_e sel;
  logic wr_lo, wr_hi, hit;
  logic [DATA_W-1:0] hold_q;
  logic [CNT_W-1:0] cnt_q;
  logic en_q;

  assign sel   = reg_sel_e'(wr_sel);
  assign wr_lo = wr_en && (sel == SEL_LO);
  assign wr_hi = wr_en && (sel == SEL_HI);

  cit_stage #(.DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst(rst), .load_i(wr_lo), .data_i(wr_data), .hold_o(hold_q)
  );

  cit_count #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_count (
    .clk(clk), .rst(rst), .commit_i(wr_hi), .data_i(wr_data), .hold_i(hold_q),
    .cyc_en_i(cyc_en), .cnt_o(cnt_q), .en_o(en_q), .hit_o(hit)
  );

  cit_irq_out u_irq (
    .clk(clk), .rst(rst), .ack_i(wr_hi), .fire_i(hit), .irq_n_o(irq_n)
  );
endmodule

// File: rtl/cit_checker.sv
module cit_checker #(
  parameter int CNT_W  = 15,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              cyc_en,
  input logic [DATA_W-1:0] hold,
  input logic [CNT_W-1:0]  cnt,
  input logic              en,
  input logic              irq_n
);
  localparam int HI_W = CNT_W - DATA_W;

  // R1: a low write alone leaves the count unchanged
  a_r1_lo_keeps_count: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel && !(cyc_en && en && cnt != '0)) |=> $stable(cnt));

  // R2: a high write loads the composite value
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel) |=> (cnt == $past({wr_data[HI_W-1:0], hold})));

  // R3: with the enable clear and no high write, the count holds
  a_r3_idle: assert property (@(posedge clk) disable iff (rst)
    (!en && !(wr_en && wr_sel)) |=> $stable(cnt));

  // R4: a high write releases the interrupt line
  a_r4_ack: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel) |=> irq_n);

  // R5: a counting edge drops the count by one
  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && wr_sel) && cyc_en && en && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R6: the interrupt only falls with the timer stopped at zero
  a_r6_stopped: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> (cnt == '0 && !en));

  // R7: running with a zero count never decrements
  a_r7_zero_hold: assert property (@(posedge clk) disable iff (rst)
    (en && cnt == '0 && !(wr_en && wr_sel)) |=> (cnt == '0));
endmodule

bind cyc_irq_timer cit_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .cyc_en(cyc_en), .hold(hold_q), .cnt(cnt_q), .en(en_q), .irq_n(irq_n)
);

// File: tb/tb_cyc_irq_timer.sv
`timescale 1ns/1ps
module tb_cyc_irq_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_sel = 1'b0, cyc_en = 1'b1;
  logic [7:0] wr_data = '0;
  logic irq_n;

  int total = 0, bad = 0;
  string cur = "R8";
  bit done = 1'b0;

  always #4 clk = ~clk;

  cyc_irq_timer dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
                     .wr_data(wr_data), .cyc_en(cyc_en), .irq_n(irq_n));

  // behavioural reference model
  int m_hold = 0, m_cnt = 0;
  bit m_en = 0, m_hit = 0, m_irqn = 1;
  always @(posedge clk) begin
    bit nh;
    nh = 0;
    if (rst) begin
      m_hold = 0; m_cnt = 0; m_en = 0; m_hit = 0; m_irqn = 1;
    end else begin
      if (wr_en && wr_sel) begin
        m_cnt = (wr_data % 128) * 256 + m_hold;
        m_en = wr_data[7];
      end else if (cyc_en && m_en && m_cnt > 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin m_en = 0; nh = 1; end
      end
      if (wr_en && !wr_sel) m_hold = wr_data;
      if (wr_en && wr_sel) m_irqn = 1;
      else if (m_hit) m_irqn = 0;
      m_hit = nh;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) if (!rst && !done) begin
    total++;
    if (irq_n !== m_irqn) begin
      bad++;
      $display("FAIL %s model compare: irq_n=%0b expected %0b at %0t", cur, irq_n, m_irqn, $time);
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: irq_n=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    chk("R8 reset", irq_n, 1'b1);
    rst = 1'b0;
    idle(2);
    chk("R8 after reset", irq_n, 1'b1);

    // R9 / R6: load 5, fires after edge 6
    cur = "R9";
    wr(0, 8'h05); wr(1, 8'h80);
    idle(5); chk("R9 still high at N", irq_n, 1'b1);
    idle(1); chk("R9 low at N+1", irq_n, 1'b0);
    cur = "R6";
    idle(10); chk("R6 held low", irq_n, 1'b0);

    // R4 ack, R3 disabled
    cur = "R4";
    wr(1, 8'h00); chk("R4 ack", irq_n, 1'b1);
    cur = "R3";
    idle(20); chk("R3 disabled no fire", irq_n, 1'b1);

    // R1 low write during a count
    cur = "R1";
    wr(0, 8'h0A); wr(1, 8'h80);
    idle(3); wr(0, 8'hFF); idle(6);
    chk("R1 high at N", irq_n, 1'b1);
    idle(1); chk("R1 low at N+1", irq_n, 1'b0);

    // R5 irregular cycle enable, load 259
    cur = "R5";
    wr(0, 8'h03); wr(1, 8'h81);
    for (int i = 0; i < 700; i++) begin
      cyc_en = (i % 3) != 1;
      @(negedge clk);
    end
    cyc_en = 1'b1;
    chk("R5 fired after gated count", irq_n, 1'b0);

    // R7 zero load enabled
    cur = "R7";
    wr(0, 8'h00); wr(1, 8'h80);
    chk("R7 ack", irq_n, 1'b1);
    idle(50); chk("R7 no fire", irq_n, 1'b1);

    // R4 ack on the edge the interrupt would assert
    cur = "R4";
    wr(0, 8'h01); wr(1, 8'h80);
    idle(1); wr(1, 8'h00);
    chk("R4 ack priority", irq_n, 1'b1);
    idle(5); chk("R4 stays high", irq_n, 1'b1);

    // R4 reload mid-count: 100 then 3
    wr(0, 8'h64); wr(1, 8'h80); idle(50);
    wr(0, 8'h03); wr(1, 8'h80);
    idle(3); chk("R4 reload high at N", irq_n, 1'b1);
    idle(1); chk("R4 reload fires at N+1", irq_n, 1'b0);

    // R2 high bits: 512
    cur = "R2";
    wr(0, 8'h00); wr(1, 8'h82);
    idle(512); chk("R2 512 high at N", irq_n, 1'b1);
    idle(1); chk("R2 512 low at N+1", irq_n, 1'b0);

    // R2 full scale 32767
    wr(0, 8'hFF); wr(1, 8'hFF);
    idle(32767); chk("R2 max high at N", irq_n, 1'b1);
    idle(1); chk("R2 max low at N+1", irq_n, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule